// File: doc/BRIEF.md
# Quad-Issue Group Slot Checker

This block sits in a four-wide, in-order dispatch stage. Each cycle it receives up to four decoded instruction-class codes, oldest first. It decides how long a prefix of them can leave together as one issue group. Every instruction in that prefix gets a slot. Instructions that need an integer unit also get a unit. Instructions past the cut are not issued and are left for a later cycle.

The decision depends only on the class codes and their positions. Structural limits set the cut:
- two asymmetric integer units that must be used in program order;
- a narrow set of slots for integer and memory work;
- single load/store, control-transfer, FP-add and FP-multiply ports;
- a rule that keeps single- and double-precision FP in separate groups.

Operand readiness and latency are outside this block. The verdict is registered one cycle after the request, together with a valid flag.

Top module: `qi_group_slot_check`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0, out_count is 0, and every out_slot and out_iu entry is 0.
- R2: out_valid equals in_valid of the previous cycle. out_count is 0 exactly when out_valid is 0. Otherwise out_count is at least 1.
- R3: Integer, load and store classes (codes 0 to 4) may only occupy positions 0, 1 and 2. One of these in position 3 ends the group before it.
- R4: FP classes (codes 7 to 10) and conditional branches (code 5) may occupy any position, including 3.
- R5: out_iu encodes 0 = no unit, 1 = integer unit 0, 2 = integer unit 1.
  - A shift (code 1) uses only unit 0.
  - A compare (code 2) uses only unit 1.
  - A plain ALU op (code 0) uses unit 0 if it is free, else unit 1.
  - A group holds at most two integer-unit users.
- R6: When both integer units are used, the unit-0 instruction must be older than the unit-1 instruction. An instruction that would need unit 0 after unit 1 is taken ends the group.
- R7: Serializing classes (codes 13, 14, 15) issue only in position 0, and always as a group of one.
- R8: A call/jump/unconditional branch (code 6) issues only in position 0. It takes the control-transfer port and integer unit 1, so out_iu reports 2 for it.
- R9: A group never mixes single-precision FP (codes 7, 9, 11) with double-precision FP (codes 8, 10, 12). Each precision is limited to FP_LANES instructions.
- R10: FP divide/square root (code 11 single, code 12 double) issues only in position 0 and occupies the FP-multiply port.
- R11: A group holds at most one load/store (codes 3, 4), one control transfer (codes 5, 6), one FP add (codes 7, 8) and one FP-multiply-port user (codes 9 to 12).
- R12: in_last gives the index of the newest present instruction, so out_count never exceeds in_last+1.
  - out_slot[i] equals i for an issued instruction and 0 for one that is not issued.
  - out_iu is 0 for instructions that are not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A candidate group is presented |
| in_class | input | N*4 | Class code per position, position 0 oldest |
| in_last | input | clog2(N) | Index of the newest present instruction |
| out_valid | output | 1 | Registered verdict is valid |
| out_count | output | clog2(N+1) | Number of instructions issued, from the oldest |
| out_slot | output | N*clog2(N) | Slot index per position |
| out_iu | output | N*2 | Integer unit per position |

## Verification
The bench targets the integer-unit ordering cases, such as a compare before a shift, a compare before an ALU op, and two ALU ops.
- A design that ignored ordering would issue compare-then-shift as two instructions.
- A design with greedy unit choice gone wrong would report the wrong unit for the ALU ops.

Restricted-slot classes in position 3 and precision mixing are checked; a leaky check would lengthen the group. Position-0-only classes placed later are checked; a leaky check would let a divide or call ride behind other work. Random class streams with idle gaps are compared every cycle against a prefix-legality model. That comparison also catches port double-booking and in_last overruns.

// File: rtl/qi_pkg.sv
package qi_pkg;
   localparam int CLS_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CL_IALU    = 4'd0,
      CL_SHIFT   = 4'd1,
      CL_CMP     = 4'd2,
      CL_LOAD    = 4'd3,
      CL_STORE   = 4'd4,
      CL_BRANCH  = 4'd5,
      CL_CALL    = 4'd6,
      CL_FADD_S  = 4'd7,
      CL_FADD_D  = 4'd8,
      CL_FMUL_S  = 4'd9,
      CL_FMUL_D  = 4'd10,
      CL_FDIV_S  = 4'd11,
      CL_FDIV_D  = 4'd12,
      CL_SER_A   = 4'd13,
      CL_SER_B   = 4'd14,
      CL_SER_C   = 4'd15
   } qi_class_e;

   localparam logic [1:0] IU_NONE = 2'd0;
   localparam logic [1:0] IU_ZERO = 2'd1;
   localparam logic [1:0] IU_ONE  = 2'd2;

   typedef struct packed {
      logic alone;      // issues by itself
      logic slot0_only; // must lead the group
      logic narrow;     // limited to the low slots
      logic need_u0;
      logic need_u1;
      logic any_u;
      logic lsu;
      logic cti;
      logic fpa;
      logic fpm;
      logic fp_s;
      logic fp_d;
   } qi_attr_t;
endpackage

// File: rtl/qi_class_decode.sv
module qi_class_decode
   import qi_pkg::*;
(
   input  logic [CLS_W-1:0] code,
   output qi_attr_t         attr
);
   always_comb begin
      attr = '0;
      unique case (qi_class_e'(code))
         CL_IALU:   begin attr.narrow = 1'b1; attr.any_u = 1'b1; end
         CL_SHIFT:  begin attr.narrow = 1'b1; attr.need_u0 = 1'b1; end
         CL_CMP:    begin attr.narrow = 1'b1; attr.need_u1 = 1'b1; end
         CL_LOAD,
         CL_STORE:  begin attr.narrow = 1'b1; attr.lsu = 1'b1; end
         CL_BRANCH: attr.cti = 1'b1;
         CL_CALL:   begin attr.slot0_only = 1'b1; attr.cti = 1'b1; attr.need_u1 = 1'b1; end
         CL_FADD_S: begin attr.fpa = 1'b1; attr.fp_s = 1'b1; end
         CL_FADD_D: begin attr.fpa = 1'b1; attr.fp_d = 1'b1; end
         CL_FMUL_S: begin attr.fpm = 1'b1; attr.fp_s = 1'b1; end
         CL_FMUL_D: begin attr.fpm = 1'b1; attr.fp_d = 1'b1; end
         CL_FDIV_S: begin attr.slot0_only = 1'b1; attr.fpm = 1'b1; attr.fp_s = 1'b1; end
         CL_FDIV_D: begin attr.slot0_only = 1'b1; attr.fpm = 1'b1; attr.fp_d = 1'b1; end
         default:   begin attr.alone = 1'b1; attr.slot0_only = 1'b1; end
      endcase
   end
endmodule

// File: rtl/qi_group_scan.sv
module qi_group_scan
   import qi_pkg::*;
#(
   parameter int N        = 4,
   parameter int NARROW   = 3,
   parameter int FP_LANES = 2,
   localparam int LW      = (N > 1) ? $clog2(N) : 1,
   localparam int CW      = $clog2(N + 1)
)(
   input  qi_attr_t [N-1:0]       attr,
   input  logic [LW-1:0]          last,
   output logic [CW-1:0]          count,
   output logic [N-1:0]           take,
   output logic [N-1:0][1:0]      iu
);
   logic     stop, ok, u0, u1, lsu, cti, fpa, fpm;
   int       nsp, ndp, cnt;
   qi_attr_t a;

   always_comb begin
      take = '0;
      iu   = '0;
      stop = 1'b0;
      ok   = 1'b0;
      u0 = 1'b0; u1 = 1'b0; lsu = 1'b0; cti = 1'b0; fpa = 1'b0; fpm = 1'b0;
      nsp = 0; ndp = 0; cnt = 0;
      a = '0;
      for (int i = 0; i < N; i++) begin
         a  = attr[i];
         ok = !stop && (i <= int'(last));
         if (a.alone && i != 0)                          ok = 1'b0;
         if (a.slot0_only && i != 0)                     ok = 1'b0;
         if (a.narrow && i >= NARROW)                    ok = 1'b0;
         if (a.need_u0 && (u0 || u1))                    ok = 1'b0;
         if ((a.need_u1 || a.any_u) && u1)               ok = 1'b0;
         if ((a.lsu && lsu) || (a.cti && cti))           ok = 1'b0;
         if ((a.fpa && fpa) || (a.fpm && fpm))           ok = 1'b0;
         if (a.fp_s && (ndp != 0 || nsp >= FP_LANES))    ok = 1'b0;
         if (a.fp_d && (nsp != 0 || ndp >= FP_LANES))    ok = 1'b0;
         if (ok) begin
            take[i] = 1'b1;
            cnt     = cnt + 1;
            if (a.need_u0) begin
               iu[i] = IU_ZERO; u0 = 1'b1;
            end else if (a.need_u1) begin
               iu[i] = IU_ONE;  u1 = 1'b1;
            end else if (a.any_u) begin
               if (!u0) begin iu[i] = IU_ZERO; u0 = 1'b1; end
               else     begin iu[i] = IU_ONE;  u1 = 1'b1; end
            end
            lsu = lsu | a.lsu;
            cti = cti | a.cti;
            fpa = fpa | a.fpa;
            fpm = fpm | a.fpm;
            if (a.fp_s) nsp = nsp + 1;
            if (a.fp_d) ndp = ndp + 1;
            if (a.alone) stop = 1'b1;
         end else begin
            stop = 1'b1;
         end
      end
      count = CW'(cnt);
   end
endmodule

// File: rtl/qi_group_slot_check.sv
module qi_group_slot_check
   import qi_pkg::*;
#(
   parameter int N        = 4,
   parameter int NARROW   = 3,
   parameter int FP_LANES = 2,
   localparam int LW      = (N > 1) ? $clog2(N) : 1,
   localparam int CW      = $clog2(N + 1)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [N-1:0][CLS_W-1:0]  in_class,
   input  logic [LW-1:0]            in_last,
   output logic                     out_valid,
   output logic [CW-1:0]            out_count,
   output logic [N-1:0][LW-1:0]     out_slot,
   output logic [N-1:0][1:0]        out_iu
);
   if (N < 2 || N > 8) begin : g_bad_n
      $error("qi_group_slot_check: N must be 2..8");
   end
   if (NARROW < 1 || NARROW > N) begin : g_bad_narrow
      $error("qi_group_slot_check: NARROW must be 1..N");
   end
   if (FP_LANES < 1) begin : g_bad_fp
      $error("qi_group_slot_check: FP_LANES must be at least 1");
   end

   qi_attr_t [N-1:0]    attr;
   logic [CW-1:0]       cnt_n;
   logic [N-1:0]        take;
   logic [N-1:0][1:0]   iu_n;
   logic [N-1:0][LW-1:0] slot_n;

   for (genvar g = 0; g < N; g++) begin : g_dec
      qi_class_decode u_dec (.code(in_class[g]), .attr(attr[g]));
      assign slot_n[g] = take[g] ? LW'(g) : '0;
   end

   qi_group_scan #(.N(N), .NARROW(NARROW), .FP_LANES(FP_LANES)) u_scan (
      .attr  (attr),
      .last  (in_last),
      .count (cnt_n),
      .take  (take),
      .iu    (iu_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_count <= '0;
         out_slot  <= '0;
         out_iu    <= '0;
      end else begin
         out_valid <= in_valid;
         out_count <= in_valid ? cnt_n  : '0;
         out_slot  <= in_valid ? slot_n : '0;
         out_iu    <= in_valid ? iu_n   : '0;
      end
   end
endmodule

// File: rtl/qi_group_slot_check_sva.sv
module qi_group_slot_check_sva
   import qi_pkg::*;
#(
   parameter int N        = 4,
   parameter int NARROW   = 3,
   parameter int FP_LANES = 2,
   localparam int LW      = (N > 1) ? $clog2(N) : 1,
   localparam int CW      = $clog2(N + 1)
)(
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [N-1:0][CLS_W-1:0]  in_class,
   input logic [LW-1:0]            in_last,
   input logic                     out_valid,
   input logic [CW-1:0]            out_count,
   input logic [N-1:0][1:0]        out_iu
);
   logic [N-1:0] iu0_mask, iu1_mask;
   for (genvar g = 0; g < N; g++) begin : g_m
      assign iu0_mask[g] = (out_iu[g] == IU_ZERO);
      assign iu1_mask[g] = (out_iu[g] == IU_ONE);
   end

   // R2
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));
   p_zero_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_count == '0) == !out_valid));
   // R12
   p_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (int'(out_count) <= int'($past(in_last)) + 1));
   // R7
   p_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class[0] >= CLS_W'(CL_SER_A)) |=> (out_count == CW'(1)));
   // R8
   p_call_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class[1] == CLS_W'(CL_CALL)) |=> (out_count <= CW'(1)));
   // R5
   p_iu_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(iu0_mask) <= 1) && ($countones(iu1_mask) <= 1));
endmodule

bind qi_group_slot_check qi_group_slot_check_sva #(
   .N(N), .NARROW(NARROW), .FP_LANES(FP_LANES)
) u_sva (.*);

// File: tb/qi_group_slot_check_bench.sv
module qi_group_slot_check_bench;
   localparam int N = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [N-1:0][3:0] in_class = '0;
   logic [1:0]      in_last = '0;
   logic            out_valid;
   logic [2:0]      out_count;
   logic [N-1:0][1:0] out_slot;
   logic [N-1:0][1:0] out_iu;

   always #2 clk = ~clk;

   qi_group_slot_check u_qi_group_slot_check (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_last(in_last), .out_valid(out_valid), .out_count(out_count),
      .out_slot(out_slot), .out_iu(out_iu)
   );

   int checks = 0, failures = 0;
   bit done = 0;
   bit pend = 0;
   int exp_v, exp_c;
   int exp_iu[4];
   string exp_tag;

   task automatic chk(bit good, string tag, string what, int act, int expv);
      checks++;
      if (!good) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // Is the k-instruction prefix a legal group?
   function automatic bit legal(int c[4], int k);
      int lsu = 0, cti = 0, fpa = 0, fpm = 0, sp = 0, dp = 0;
      int ints[$];
      for (int p = 0; p < k; p++) begin
         if (c[p] >= 13 && k > 1) return 0;
         if ((c[p] == 6 || c[p] == 11 || c[p] == 12) && p != 0) return 0;
         if (c[p] <= 4 && p >= 3) return 0;
         if (c[p] == 3 || c[p] == 4) lsu++;
         if (c[p] == 5 || c[p] == 6) cti++;
         if (c[p] == 7 || c[p] == 8) fpa++;
         if (c[p] >= 9 && c[p] <= 12) fpm++;
         if (c[p] == 7 || c[p] == 9 || c[p] == 11) sp++;
         if (c[p] == 8 || c[p] == 10 || c[p] == 12) dp++;
         if (c[p] <= 2 || c[p] == 6) ints.push_back(c[p]);
      end
      if (lsu > 1 || cti > 1 || fpa > 1 || fpm > 1) return 0;
      if ((sp > 0 && dp > 0) || sp > 2 || dp > 2) return 0;
      if (ints.size() > 2) return 0;
      if (ints.size() == 2 && (ints[0] == 2 || ints[0] == 6 || ints[1] == 1)) return 0;
      return 1;
   endfunction

   task automatic drive(bit v, int c0, int c1, int c2, int c3, int last, string tag);
      int c[4];
      int k, seen;
      @(negedge clk);
      if (pend) begin
         chk(out_valid == exp_v[0], exp_tag, "valid", out_valid, exp_v);
         chk(int'(out_count) == exp_c, exp_tag, "count", out_count, exp_c);
         for (int i = 0; i < 4; i++) begin
            chk(int'(out_slot[i]) == ((i < exp_c) ? i : 0), exp_tag, "slot",
                out_slot[i], (i < exp_c) ? i : 0);
            chk(int'(out_iu[i]) == exp_iu[i], exp_tag, "iu", out_iu[i], exp_iu[i]);
         end
      end
      c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
      in_valid = v;
      in_last  = 2'(last);
      for (int i = 0; i < 4; i++) in_class[i] = 4'(c[i]);
      exp_v = v;
      exp_tag = tag;
      k = 0;
      if (v) for (int t = last + 1; t >= 1; t--) if (k == 0 && legal(c, t)) k = t;
      exp_c = k;
      seen = 0;
      for (int i = 0; i < 4; i++) begin
         exp_iu[i] = 0;
         if (i < k && (c[i] <= 2 || c[i] == 6)) begin
            if (seen == 0) exp_iu[i] = (c[i] == 2 || c[i] == 6) ? 2 : 1;
            else           exp_iu[i] = 2;
            seen++;
         end
      end
      pend = 1;
   endtask

   initial begin
      #6000000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs cleared under reset
      chk(out_valid == 0 && out_count == 0 && out_slot == '0 && out_iu == '0,
          "R1", "reset", out_count, 0);
      rst_n = 1'b1;
      drive(0, 0, 0, 0, 0, 3, "R2 idle");
      drive(1, 3, 7, 9, 3, 3, "R3 load in slot3");
      drive(1, 3, 7, 9, 5, 3, "R4 fp+branch all slots");
      drive(1, 1, 2, 5, 7, 3, "R5 shift then cmp");
      drive(1, 0, 0, 7, 9, 3, "R5 two alu");
      drive(1, 2, 1, 7, 9, 3, "R6 cmp before shift");
      drive(1, 2, 0, 7, 9, 3, "R6 cmp before alu");
      drive(1, 13, 7, 5, 3, 3, "R7 serial lead");
      drive(1, 0, 14, 7, 5, 3, "R7 serial second");
      drive(1, 6, 5, 7, 9, 3, "R8 call then branch");
      drive(1, 6, 0, 7, 9, 3, "R8 call then alu");
      drive(1, 6, 3, 7, 9, 3, "R8 call then load");
      drive(1, 5, 6, 7, 9, 3, "R8 call second");
      drive(1, 7, 10, 5, 3, 3, "R9 mixed precision");
      drive(1, 8, 10, 5, 3, 3, "R9 double pair");
      drive(1, 11, 9, 5, 3, 3, "R10 div then mul");
      drive(1, 7, 11, 5, 3, 3, "R10 div second");
      drive(1, 12, 8, 5, 3, 3, "R10 div then add");
      drive(1, 3, 4, 7, 9, 3, "R11 two lsu");
      drive(1, 5, 5, 7, 9, 3, "R11 two cti");
      drive(1, 7, 7, 5, 3, 3, "R11 two fadd");
      drive(1, 3, 7, 9, 5, 1, "R12 last=1");
      drive(1, 0, 5, 7, 9, 0, "R12 last=0");
      for (int n = 0; n < 3000; n++)
         drive(($urandom_range(7, 0) != 0), $urandom_range(15, 0), $urandom_range(15, 0),
               $urandom_range(15, 0), $urandom_range(15, 0), $urandom_range(3, 0),
               "RND R3 R4 R5 R6 R9 R11 R12");
      drive(0, 0, 0, 0, 0, 0, "R2 flush");
      @(negedge clk);
      chk(out_valid == 0 && out_count == 0, "R2", "final idle", out_count, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule